// File: doc/BRIEF.md
# Sensor Threshold Alarm Evaluator

This block watches a set of 8-bit sensor readings and decides, every clock, which channels are in alarm. There are two groups. The first group has up to sixteen channels, each either a temperature probe or a voltage rail, chosen by a per-channel type bit. Each channel has a behaviour byte and two threshold bytes. The second group has up to six fan-speed channels, each with a behaviour byte and one minimum-speed threshold.

From these inputs the block produces a packed alarm summary, one bit per channel. It also produces a read-back status byte per first-group channel, in which the cause bits are sticky. Two requests leave the block. A beep request is high while any alarming channel asks for a beep. A shutdown request is held once raised. Temperature shutdown is immediate. Voltage and fan shutdown need the alarm to persist across more than a programmable number of ticks. The tick input has a known period, so that count stands for the four-second hold.

A register stage sits at every output. The block does not convert readings to physical units and has no bus access to the settings: the surrounding logic supplies the settings as plain vectors.

Top module: `sae_alarm_eval`

## Requirements
- R1: Synchronous active-high reset clears `alarm_summary`, `beep_req`, `shutdown_req` and every `vt_status` byte to zero. Each output is registered and reflects the inputs present at the previous rising edge.
- R2: On a first-group channel whose type bit is 1 (temperature), behaviour bit 0 raises the alarm when the reading is strictly greater than the low threshold byte (the warning level). A reading equal to it gives no alarm. Behaviour bits 1 and 2 have no effect on such a channel.
- R3: On a first-group channel whose type bit is 0 (voltage), behaviour bit 1 raises the alarm when the reading is strictly greater than the high threshold byte (the maximum). Behaviour bit 2 raises it when the reading is strictly less than the low threshold byte (the minimum). Equal values give no alarm, and behaviour bit 0 has no effect on such a channel.
- R4: The status byte of a first-group channel carries behaviour bits 0-3 and 7 unchanged. Bit 4 is a sticky flag for over-warning, bit 5 for over-maximum and bit 6 for under-minimum; each stays set until reset. Behaviour input bits 4-6 are ignored.
- R5: A fan channel is in alarm when its behaviour bit 0 is set and its reading is strictly less than its minimum threshold.
- R6: Summary layout: bit n (0-15) is first-group channel n. Bit 16+m is fan channel m. Bits 22 and 23 are always zero.
- R7: `beep_req` is high exactly when at least one channel is in alarm with behaviour bit 3 set.
- R8: A temperature channel with behaviour bit 7 set raises `shutdown_req` when its reading is strictly greater than the high threshold byte (the shutdown level), whether or not behaviour bit 0 is set.
- R9: A voltage or fan channel with behaviour bit 7 set raises `shutdown_req` once its alarm has lasted through more than `HOLD_TICKS` tick pulses. Exactly `HOLD_TICKS` pulses are not enough.
- R10: When a voltage or fan alarm drops for even one clock, its persistence count restarts from zero.
- R11: Once raised, `shutdown_req` stays high until reset, even after every condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse of fixed period for persistence timing |
| vt_is_temp | input | NUM_VT | Per-channel type: 1 temperature, 0 voltage |
| vt_reading | input | NUM_VT*8 | First-group readings, channel n in bits 8n+7:8n |
| vt_behav | input | NUM_VT*8 | First-group behaviour bytes |
| vt_lo_thr | input | NUM_VT*8 | Warning level (temperature) or minimum (voltage) |
| vt_hi_thr | input | NUM_VT*8 | Shutdown level (temperature) or maximum (voltage) |
| fan_reading | input | NUM_FAN*8 | Fan-speed readings |
| fan_behav | input | NUM_FAN*8 | Fan behaviour bytes |
| fan_min_thr | input | NUM_FAN*8 | Fan minimum-speed thresholds |
| vt_status | output | NUM_VT*8 | Read-back status byte per first-group channel |
| alarm_summary | output | 24 | Packed live alarm bits |
| beep_req | output | 1 | Beep request |
| shutdown_req | output | 1 | Latched shutdown request |

## Verification
If a channel's sticky cause state goes wrong, the status byte shows it at the next clock. The bench's own sticky model then disagrees on every later comparison, so one missed set or one spurious clear stays visible. If a persistence counter fails to restart or saturate, `shutdown_req` rises one tick pulse early, or never rises. The bench counts pulses one by one around the `HOLD_TICKS` boundary to catch this. If a comparator swaps strict and non-strict comparison, the summary bit flips at the very next clock for readings equal to a threshold.

// File: rtl/sae_pkg.sv
package sae_pkg;
  localparam int BYTE_W    = 8;
  localparam int VT_SLOTS  = 16;
  localparam int FAN_SLOTS = 8;
  localparam int SUM_W     = VT_SLOTS + FAN_SLOTS;

  // behaviour byte bit positions
  localparam int B_EN_WARN  = 0;
  localparam int B_EN_OVER  = 1;
  localparam int B_EN_UNDER = 2;
  localparam int B_BEEP     = 3;
  localparam int B_SHDN     = 7;
  localparam int B_FAN_LOW  = 0;

  // status byte cause field position (warn, over, under)
  localparam int B_CAUSE_LO = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic alarm;
    logic beep;
    logic shdn;
  } chan_req_t;
endpackage

// File: rtl/sae_persist.sv
module sae_persist #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(HOLD_TICKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS + 1);

  logic [CW-1:0] cnt_q;

  // count tick pulses while active; restart the moment the condition drops
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/sae_vt_chan.sv
module sae_vt_chan
  import sae_pkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      is_temp,
  input  byte_t     reading,
  input  byte_t     behav,
  input  byte_t     lo_thr,
  input  byte_t     hi_thr,
  output chan_req_t req,
  output byte_t     status
);
  logic       over_warn, over_max, under_min;
  logic       volt_active, volt_expired, temp_trip;
  logic [2:0] cause_now;
  byte_t      status_q;
  logic       unused_behav;

  always_comb begin
    over_warn = is_temp  && behav[B_EN_WARN]  && (reading > lo_thr);
    over_max  = !is_temp && behav[B_EN_OVER]  && (reading > hi_thr);
    under_min = !is_temp && behav[B_EN_UNDER] && (reading < lo_thr);
    cause_now = {under_min, over_max, over_warn};
    volt_active = over_max || under_min;
    temp_trip = is_temp && behav[B_SHDN] && (reading > hi_thr);
  end

  sae_persist #(.HOLD_TICKS(HOLD_TICKS)) u_persist (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .active (volt_active),
    .expired(volt_expired)
  );

  always_comb begin
    req.alarm = |cause_now;
    req.beep  = (|cause_now) && behav[B_BEEP];
    req.shdn  = temp_trip || (!is_temp && behav[B_SHDN] && volt_expired);
  end

  // status: control bits mirrored, cause field accumulates until reset
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else begin
      status_q[B_SHDN]                <= behav[B_SHDN];
      status_q[B_CAUSE_LO +: 3]       <= status_q[B_CAUSE_LO +: 3] | cause_now;
      status_q[B_BEEP:B_EN_WARN]      <= behav[B_BEEP:B_EN_WARN];
    end
  end

  assign status = status_q;
  assign unused_behav = ^behav[B_CAUSE_LO +: 3];
endmodule

// File: rtl/sae_fan_chan.sv
module sae_fan_chan
  import sae_pkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  byte_t     reading,
  input  byte_t     behav,
  input  byte_t     min_thr,
  output chan_req_t req
);
  logic too_slow, slow_expired;
  logic unused_behav;

  assign too_slow = behav[B_FAN_LOW] && (reading < min_thr);

  sae_persist #(.HOLD_TICKS(HOLD_TICKS)) u_persist (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .active (too_slow),
    .expired(slow_expired)
  );

  always_comb begin
    req.alarm = too_slow;
    req.beep  = too_slow && behav[B_BEEP];
    req.shdn  = behav[B_SHDN] && slow_expired;
  end

  assign unused_behav = ^{behav[6:4], behav[2:1]};
endmodule

// File: rtl/sae_alarm_eval.sv
module sae_alarm_eval
  import sae_pkg::*;
#(
  parameter int NUM_VT     = 16,
  parameter int NUM_FAN    = 6,
  parameter int HOLD_TICKS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [NUM_VT-1:0]       vt_is_temp,
  input  logic [NUM_VT*8-1:0]     vt_reading,
  input  logic [NUM_VT*8-1:0]     vt_behav,
  input  logic [NUM_VT*8-1:0]     vt_lo_thr,
  input  logic [NUM_VT*8-1:0]     vt_hi_thr,
  input  logic [NUM_FAN*8-1:0]    fan_reading,
  input  logic [NUM_FAN*8-1:0]    fan_behav,
  input  logic [NUM_FAN*8-1:0]    fan_min_thr,
  output logic [NUM_VT*8-1:0]     vt_status,
  output logic [SUM_W-1:0]        alarm_summary,
  output logic                    beep_req,
  output logic                    shutdown_req
);
  chan_req_t vt_req  [NUM_VT];
  chan_req_t fan_req [NUM_FAN];

  logic [SUM_W-1:0] sum_next;
  logic             beep_next, shdn_next;
  logic [SUM_W-1:0] sum_q;
  logic             beep_q, shdn_q;

  for (genvar i = 0; i < NUM_VT; i++) begin : g_vt
    sae_vt_chan #(.HOLD_TICKS(HOLD_TICKS)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .is_temp(vt_is_temp[i]),
      .reading(vt_reading[i*BYTE_W +: BYTE_W]),
      .behav  (vt_behav[i*BYTE_W +: BYTE_W]),
      .lo_thr (vt_lo_thr[i*BYTE_W +: BYTE_W]),
      .hi_thr (vt_hi_thr[i*BYTE_W +: BYTE_W]),
      .req    (vt_req[i]),
      .status (vt_status[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar j = 0; j < NUM_FAN; j++) begin : g_fan
    sae_fan_chan #(.HOLD_TICKS(HOLD_TICKS)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .reading(fan_reading[j*BYTE_W +: BYTE_W]),
      .behav  (fan_behav[j*BYTE_W +: BYTE_W]),
      .min_thr(fan_min_thr[j*BYTE_W +: BYTE_W]),
      .req    (fan_req[j])
    );
  end

  // gather per-channel requests into the packed summary and the two requests
  always_comb begin
    sum_next  = '0;
    beep_next = 1'b0;
    shdn_next = 1'b0;
    for (int i = 0; i < NUM_VT; i++) begin
      sum_next[i] = vt_req[i].alarm;
      beep_next   = beep_next | vt_req[i].beep;
      shdn_next   = shdn_next | vt_req[i].shdn;
    end
    for (int j = 0; j < NUM_FAN; j++) begin
      sum_next[VT_SLOTS + j] = fan_req[j].alarm;
      beep_next = beep_next | fan_req[j].beep;
      shdn_next = shdn_next | fan_req[j].shdn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      beep_q <= 1'b0;
      shdn_q <= 1'b0;
    end else begin
      sum_q  <= sum_next;
      beep_q <= beep_next;
      shdn_q <= shdn_q | shdn_next;
    end
  end

  assign alarm_summary = sum_q;
  assign beep_req      = beep_q;
  assign shutdown_req  = shdn_q;
endmodule

// File: rtl/sae_alarm_eval_chk.sv
module sae_alarm_eval_chk
  import sae_pkg::*;
#(
  parameter int NUM_VT = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_VT-1:0]   vt_is_temp,
  input logic [NUM_VT*8-1:0] vt_reading,
  input logic [NUM_VT*8-1:0] vt_behav,
  input logic [NUM_VT*8-1:0] vt_lo_thr,
  input logic [NUM_VT*8-1:0] vt_hi_thr,
  input logic [NUM_VT*8-1:0] vt_status,
  input logic [SUM_W-1:0]    alarm_summary,
  input logic                beep_req,
  input logic                shutdown_req
);
  logic unused_chk;
  assign unused_chk = ^{vt_behav, vt_status};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alarm_summary == '0 && !beep_req && !shutdown_req));

  // R11
  shutdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |=> shutdown_req);

  // R7
  beep_needs_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    beep_req |-> (alarm_summary != '0));

  for (genvar i = 0; i < NUM_VT; i++) begin : g_chk
    // R4
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((vt_status[i*8+B_CAUSE_LO +: 3] & $past(vt_status[i*8+B_CAUSE_LO +: 3]))
                == $past(vt_status[i*8+B_CAUSE_LO +: 3])));

    // R2
    temp_warn_chk: assert property (@(posedge clk) disable iff (rst)
      (vt_is_temp[i] && vt_behav[i*8+B_EN_WARN] &&
       (vt_reading[i*8 +: 8] > vt_lo_thr[i*8 +: 8])) |=> alarm_summary[i]);

    // R8
    temp_shdn_chk: assert property (@(posedge clk) disable iff (rst)
      (vt_is_temp[i] && vt_behav[i*8+B_SHDN] &&
       (vt_reading[i*8 +: 8] > vt_hi_thr[i*8 +: 8])) |=> shutdown_req);
  end
endmodule

bind sae_alarm_eval sae_alarm_eval_chk #(.NUM_VT(NUM_VT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .vt_is_temp   (vt_is_temp),
  .vt_reading   (vt_reading),
  .vt_behav     (vt_behav),
  .vt_lo_thr    (vt_lo_thr),
  .vt_hi_thr    (vt_hi_thr),
  .vt_status    (vt_status),
  .alarm_summary(alarm_summary),
  .beep_req     (beep_req),
  .shutdown_req (shutdown_req)
);

// File: tb/sae_alarm_eval_bench.sv
`timescale 1ns/1ps
module sae_alarm_eval_bench;
  localparam int NV = 16;
  localparam int NF = 6;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;

  logic [7:0] rd [NV], beh [NV], lo [NV], hi [NV];
  logic       tmp [NV];
  logic [7:0] frd [NF], fbeh [NF], fmin [NF];
  logic [2:0] mcause [NV];

  logic [NV-1:0]   vt_is_temp;
  logic [NV*8-1:0] vt_reading, vt_behav, vt_lo_thr, vt_hi_thr;
  logic [NF*8-1:0] fan_reading, fan_behav, fan_min_thr;
  logic [NV*8-1:0] vt_status;
  logic [23:0]     alarm_summary;
  logic            beep_req, shutdown_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NV; i++) begin
      vt_is_temp[i]        = tmp[i];
      vt_reading[i*8 +: 8] = rd[i];
      vt_behav[i*8 +: 8]   = beh[i];
      vt_lo_thr[i*8 +: 8]  = lo[i];
      vt_hi_thr[i*8 +: 8]  = hi[i];
    end
    for (int j = 0; j < NF; j++) begin
      fan_reading[j*8 +: 8] = frd[j];
      fan_behav[j*8 +: 8]   = fbeh[j];
      fan_min_thr[j*8 +: 8] = fmin[j];
    end
  end

  sae_alarm_eval #(.NUM_VT(NV), .NUM_FAN(NF), .HOLD_TICKS(HOLD)) u_sae_alarm_eval (
    .clk(clk), .rst(rst), .tick(tick),
    .vt_is_temp(vt_is_temp), .vt_reading(vt_reading), .vt_behav(vt_behav),
    .vt_lo_thr(vt_lo_thr), .vt_hi_thr(vt_hi_thr),
    .fan_reading(fan_reading), .fan_behav(fan_behav), .fan_min_thr(fan_min_thr),
    .vt_status(vt_status), .alarm_summary(alarm_summary),
    .beep_req(beep_req), .shutdown_req(shutdown_req)
  );

  // ---------------- expected-value model from the requirements
  function automatic logic [2:0] cause_of(int i);
    logic w, o, u;
    w = tmp[i]  && beh[i][0] && (rd[i] > lo[i]);
    o = !tmp[i] && beh[i][1] && (rd[i] > hi[i]);
    u = !tmp[i] && beh[i][2] && (rd[i] < lo[i]);
    return {u, o, w};
  endfunction

  function automatic logic fan_alarm(int j);
    return fbeh[j][0] && (frd[j] < fmin[j]);
  endfunction

  function automatic logic [23:0] exp_summary();
    logic [23:0] s = '0;
    for (int i = 0; i < NV; i++) s[i] = |cause_of(i);
    for (int j = 0; j < NF; j++) s[16+j] = fan_alarm(j);
    return s;
  endfunction

  function automatic logic exp_beep();
    logic b = 1'b0;
    for (int i = 0; i < NV; i++) b |= (|cause_of(i)) && beh[i][3];
    for (int j = 0; j < NF; j++) b |= fan_alarm(j) && fbeh[j][3];
    return b;
  endfunction

  // ---------------- helpers
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    for (int i = 0; i < NV; i++) begin
      rd[i] = 8'd0; beh[i] = 8'd0; lo[i] = 8'd0; hi[i] = 8'd0; tmp[i] = 1'b0;
      mcause[i] = 3'b000;
    end
    for (int j = 0; j < NF; j++) begin
      frd[j] = 8'd0; fbeh[j] = 8'd0; fmin[j] = 8'd0;
    end
  endtask

  task automatic do_reset();
    set_idle();
    rst = 1'b1;
    tick = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic tick_pulse();
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    set_idle();
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 summary", alarm_summary, 0);
    check("R1 beep", beep_req, 0);
    check("R1 shutdown", shutdown_req, 0);
    check("R1 status", vt_status[31:0], 0);

    // R2 temperature channel 3, strict over-warning, bits1/2 ignored
    tmp[3] = 1; beh[3] = 8'h07; lo[3] = 8'd100; hi[3] = 8'd200; rd[3] = 8'd100;
    step();
    check("R2 equal no alarm", alarm_summary, 0);
    rd[3] = 8'd101; step();
    check("R2 over warn", alarm_summary, 24'h000008);
    rd[3] = 8'd50; step();
    check("R2 under ignored on temp", alarm_summary, 0);
    rd[3] = 8'd250; beh[3] = 8'h06; step();
    check("R2 over max ignored on temp", alarm_summary, 0);

    // R3 voltage channel 9
    tmp[9] = 0; beh[9] = 8'h07; lo[9] = 8'd50; hi[9] = 8'd150; rd[9] = 8'd150;
    step();
    check("R3 equal max", alarm_summary, 0);
    rd[9] = 8'd151; step();
    check("R3 over max", alarm_summary, 24'h000200);
    rd[9] = 8'd50; step();
    check("R3 equal min", alarm_summary, 0);
    rd[9] = 8'd49; step();
    check("R3 under min", alarm_summary, 24'h000200);
    beh[9] = 8'h01; rd[9] = 8'd255; step();
    check("R3 bit0 ignored on volt", alarm_summary, 0);

    // R4 status read-back: ch9 saw over and under; ch3 saw warn
    check("R4 ch9 sticky causes", vt_status[9*8 +: 8], 8'h61);
    check("R4 ch3 sticky warn", vt_status[3*8 +: 8], 8'h16);
    beh[12] = 8'h70; step();
    check("R4 input bits4-6 ignored", vt_status[12*8 +: 8], 8'h00);

    // R5 / R6 fan channel 5 and channel 15 placement
    do_reset();
    fbeh[5] = 8'h01; fmin[5] = 8'd30; frd[5] = 8'd30; step();
    check("R5 fan equal min", alarm_summary, 0);
    frd[5] = 8'd29; beh[15] = 8'h02; hi[15] = 8'd10; rd[15] = 8'd11; step();
    check("R6 summary layout", alarm_summary, 24'h208000);

    // R7 beep
    fbeh[5] = 8'h09; beh[15] = 8'h02; step();
    check("R7 beep on", beep_req, 1);
    fbeh[5] = 8'h08; beh[15] = 8'h00; step();
    check("R7 beep bit without alarm", beep_req, 0);
    fbeh[5] = 8'h01; step();
    check("R7 alarm without beep bit", beep_req, 0);

    // R8 temperature immediate shutdown, R11 latch
    do_reset();
    tmp[0] = 1; beh[0] = 8'h80; hi[0] = 8'd90; rd[0] = 8'd90; step();
    check("R8 equal no shutdown", shutdown_req, 0);
    rd[0] = 8'd91; step();
    check("R8 shutdown", shutdown_req, 1);
    rd[0] = 8'd0; beh[0] = 8'h00; repeat (3) step();
    check("R11 shutdown held", shutdown_req, 1);
    do_reset();
    check("R1 shutdown cleared", shutdown_req, 0);

    // R9 voltage persistence
    tmp[2] = 0; beh[2] = 8'h84; lo[2] = 8'd100; rd[2] = 8'd10; step();
    repeat (HOLD) tick_pulse();
    check("R9 volt at hold", shutdown_req, 0);
    tick_pulse();
    check("R9 volt past hold", shutdown_req, 1);

    // R9 fan persistence, and no shutdown without bit7
    do_reset();
    fbeh[1] = 8'h81; fmin[1] = 8'd50; frd[1] = 8'd5;
    tmp[4] = 0; beh[4] = 8'h04; lo[4] = 8'd100; rd[4] = 8'd1; step();
    repeat (HOLD) tick_pulse();
    check("R9 fan at hold", shutdown_req, 0);
    fbeh[1] = 8'h01;
    repeat (HOLD + 2) tick_pulse();
    check("R9 no bit7 no shutdown", shutdown_req, 0);
    fbeh[1] = 8'h81; step();
    check("R9 fan past hold", shutdown_req, 1);

    // R10 restart on drop
    do_reset();
    tmp[2] = 0; beh[2] = 8'h84; lo[2] = 8'd100; rd[2] = 8'd10; step();
    repeat (HOLD) tick_pulse();
    rd[2] = 8'd200; step();
    rd[2] = 8'd10; step();
    repeat (HOLD) tick_pulse();
    check("R10 count restarted", shutdown_req, 0);
    tick_pulse();
    check("R10 expires after restart", shutdown_req, 1);

    // random phase: R2 R3 R4 R5 R6 R7 against the model
    do_reset();
    void'($urandom(32'd24681));
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < NV; i++) begin
        tmp[i] = 1'($urandom);
        beh[i] = 8'($urandom) & 8'h7F;
        lo[i]  = 8'($urandom);
        hi[i]  = 8'($urandom);
        rd[i]  = (it % 4 == 0) ? lo[i] : 8'($urandom);
      end
      for (int j = 0; j < NF; j++) begin
        fbeh[j] = 8'($urandom) & 8'h7F;
        fmin[j] = 8'($urandom);
        frd[j]  = 8'($urandom);
      end
      step();
      for (int i = 0; i < NV; i++) mcause[i] |= cause_of(i);
      check("R6 random summary", alarm_summary, exp_summary());
      check("R7 random beep", beep_req, exp_beep());
      check("R9 random no shutdown", shutdown_req, 0);
      for (int i = 0; i < NV; i++)
        check("R4 random status", vt_status[i*8 +: 8],
              {1'b0, mcause[i], beh[i][3:0]});
    end

    finish_run();
  end
endmodule